// File: doc/BRIEF.md
# Paper Tape Reader Bus Controller

This block sits between a programmed I/O bus and a character-at-a-time paper tape reader. The bus side delivers already-decoded reader strobes (skip test, buffer read, character fetch, and the combined read-then-fetch) together with the TP3 timing pulse. The block answers with an 8-bit data slice, the two transfer-control lines that make the processor OR the slice into its accumulator, and an active-low skip line. The reader side presents eight hole lines and an active-low ready line, and receives an active-low start pulse that advances the tape by one character.

A character flag records that a fresh character is waiting. It is set when the synchronised ready line becomes active and is cleared by any read or fetch at TP3. A fetch never pulses the start line while the reader is busy. The request is held until ready returns low. The pulse width is a parameterised count of system clock cycles, so the minimum width holds at any clock rate.

Top module: `tape_rdr_ctrl`

## Requirements
- R1: After reset, data_o is 0, xfer_c0 and xfer_c1 are 0, skip_n is 1 and start_n is 1.
- R2: In the cycle after a clock edge that sees iot_read or iot_read_fetch high, data_o equals hole_i sampled at that edge, with xfer_c0 = xfer_c1 = 1. Otherwise data_o is 0 and both transfer lines are 0.
- R3: In the cycle after a clock edge that sees iot_skip high while the character flag is set, skip_n is 0. Otherwise skip_n is 1.
- R4: ready_n passes through a two-stage synchroniser. The flag is set in the cycle after the synchronised ready changes from inactive to active. It is cleared by an edge that sees tp3 together with iot_read, iot_fetch or iot_read_fetch. A set and a clear on the same edge leave the flag set.
- R5: Each start pulse holds start_n low for exactly PULSE_CYCLES consecutive clock cycles.
- R6: An edge that sees tp3 with iot_fetch or iot_read_fetch records one start request. start_n falls only while the synchronised ready is active. A request made while ready is inactive is held, not dropped.
- R7: After a pulse ends, no new pulse starts until the synchronised ready has gone inactive and then active again.
- R8: The combined operation gates the current character onto data_o during its strobe and also issues one start pulse after TP3. The gated value is the character present before the tape advances.
- R9: A second request made while a pulse or its ready wait is in progress is kept (at most one pending) and produces a further pulse once the reader is ready again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iot_skip | input | 1 | Decoded skip-on-flag strobe |
| iot_read | input | 1 | Decoded read-buffer strobe |
| iot_fetch | input | 1 | Decoded fetch-character strobe |
| iot_read_fetch | input | 1 | Decoded combined read-then-fetch strobe |
| tp3 | input | 1 | Bus timing pulse 3, one clock wide |
| data_o | output | 8 | Character onto data bits 4-11, zero when not gated |
| xfer_c0 | output | 1 | Transfer control 0, high during a gated read |
| xfer_c1 | output | 1 | Transfer control 1, high during a gated read |
| skip_n | output | 1 | Active-low skip response |
| hole_i | input | 8 | Reader hole lines |
| ready_n | input | 1 | Reader ready, active low |
| start_n | output | 1 | Active-low tape advance pulse |

## Verification
The hardest case to reach is a start request that arrives while the reader reports busy. With a responsive reader, ready is already low again by the time software fetches. The bench has an override that holds the modelled reader's ready line inactive, issues a fetch during that window, and checks that start_n stays high throughout. It then releases the override and expects exactly one delayed pulse. Back-to-back fetches, where the second TP3 lands inside the first pulse, exercise the single pending request and the ready-wait state.

// File: rtl/tape_rdr_pkg.sv
package tape_rdr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PULSE = 2'd1,
        ST_WAIT  = 2'd2
    } start_st_e;

endpackage

// File: rtl/tape_rdr_sync.sv
module tape_rdr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_comb chain_d[i] = async_in;
        end else begin : g_rest
            always_comb chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/tape_rdr_start.sv
module tape_rdr_start
    import tape_rdr_pkg::*;
#(
    parameter int PULSE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic ready_act,
    output logic start_n
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);

    typedef struct packed {
        start_st_e      st;
        logic           pend;
        logic [CW-1:0]  cnt;
        logic           start_n;
    } start_t;

    start_t q, d;
    logic   launch;

    always_comb begin
        d      = q;
        launch = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (q.pend && ready_act) begin
                    launch    = 1'b1;
                    d.st      = ST_PULSE;
                    d.cnt     = CW'(PULSE_CYCLES - 1);
                    d.start_n = 1'b0;
                end
            end
            ST_PULSE: begin
                if (q.cnt == '0) begin
                    d.st      = ST_WAIT;
                    d.start_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_WAIT: begin
                if (!ready_act) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        d.pend = (q.pend && !launch) || req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.pend    <= 1'b0;
            q.cnt     <= '0;
            q.start_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign start_n = q.start_n;

    logic [15:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n)        low_run_q <= '0;
        else if (!start_n) low_run_q <= low_run_q + 1'b1;
        else               low_run_q <= '0;
    end

    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_n) |-> $past(ready_act)); // R6
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_n) |-> (low_run_q == 16'(PULSE_CYCLES))); // R5
endmodule

// File: rtl/tape_rdr_ctrl.sv
module tape_rdr_ctrl
    import tape_rdr_pkg::*;
#(
    parameter int DATA_W       = 8,
    parameter int SYNC_STAGES  = 2,
    parameter int PULSE_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iot_skip,
    input  logic              iot_read,
    input  logic              iot_fetch,
    input  logic              iot_read_fetch,
    input  logic              tp3,
    output logic [DATA_W-1:0] data_o,
    output logic              xfer_c0,
    output logic              xfer_c1,
    output logic              skip_n,
    input  logic [DATA_W-1:0] hole_i,
    input  logic              ready_n,
    output logic              start_n
);
    typedef struct packed {
        logic              prev;
        logic              flag;
        logic              skip_n;
        logic [DATA_W-1:0] data;
        logic              xfer;
    } bus_t;

    bus_t q, d;
    logic ready_act;
    logic gate_rd;
    logic any_op;
    logic new_char;
    logic start_req;

    tape_rdr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (~ready_n),
        .sync_out (ready_act)
    );

    assign start_req = tp3 && (iot_fetch || iot_read_fetch);

    tape_rdr_start #(.PULSE_CYCLES(PULSE_CYCLES)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (start_req),
        .ready_act (ready_act),
        .start_n   (start_n)
    );

    always_comb begin
        d        = q;
        gate_rd  = iot_read || iot_read_fetch;
        any_op   = iot_read || iot_fetch || iot_read_fetch;
        new_char = ready_act && !q.prev;
        d.prev   = ready_act;
        if (new_char)         d.flag = 1'b1;
        else if (tp3 && any_op) d.flag = 1'b0;
        d.skip_n = !(iot_skip && q.flag);
        d.data   = gate_rd ? hole_i : '0;
        d.xfer   = gate_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.prev   <= 1'b0;
            q.flag   <= 1'b0;
            q.skip_n <= 1'b1;
            q.data   <= '0;
            q.xfer   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.data;
    assign xfer_c0 = q.xfer;
    assign xfer_c1 = q.xfer;
    assign skip_n  = q.skip_n;

    AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_c0 |-> (data_o == '0)); // R2
    AST_XFER_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (iot_read || iot_read_fetch) |=> (xfer_c0 && xfer_c1)); // R2
    AST_SKIP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_n |-> $past(iot_skip)); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tp3 && (iot_read || iot_fetch || iot_read_fetch) && !(ready_act && !q.prev))
        |=> !q.flag); // R4
endmodule

// File: tb/tape_rdr_ctrl_tb.sv
module tape_rdr_ctrl_tb;
    localparam int PULSE = 6;
    localparam int DEV_CYC = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iot_skip = 0, iot_read = 0, iot_fetch = 0, iot_read_fetch = 0, tp3 = 0;
    logic [7:0] data_o;
    logic xfer_c0, xfer_c1, skip_n, start_n;
    logic [7:0] hole_i;
    logic ready_n;

    always #10 clk = ~clk;

    tape_rdr_ctrl #(.PULSE_CYCLES(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .iot_skip(iot_skip), .iot_read(iot_read),
        .iot_fetch(iot_fetch), .iot_read_fetch(iot_read_fetch), .tp3(tp3),
        .data_o(data_o), .xfer_c0(xfer_c0), .xfer_c1(xfer_c1), .skip_n(skip_n),
        .hole_i(hole_i), .ready_n(ready_n), .start_n(start_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reader model and pulse monitor
    bit force_busy = 0;
    bit dev_busy = 0;
    int dev_cnt = 0;
    int pulses = 0;
    int low_cnt = 0;
    logic start_prev = 1'b1;
    initial begin hole_i = 8'h5A; ready_n = 1'b0; end

    always @(negedge clk) begin
        if (!start_n && start_prev) begin
            pulses++;
            chk(!ready_n, "R6", "start fell while ready inactive", ready_n, 0);
        end
        if (!start_n) low_cnt++;
        if (start_n && !start_prev) begin
            chk(low_cnt == PULSE, "R5", "pulse width", low_cnt, PULSE);
            low_cnt = 0;
        end
        if (!start_n && start_prev) begin
            dev_busy = 1;
            dev_cnt = DEV_CYC;
        end else if (dev_busy) begin
            dev_cnt--;
            if (dev_cnt == 0) begin
                dev_busy = 0;
                hole_i = hole_i + 8'h11;
            end
        end
        ready_n = dev_busy | force_busy;
        start_prev = start_n;
    end

    // behavioural reference model
    bit m_s0, m_s1, m_prev, m_flag, m_skipn, m_xfer, m_pend, m_startn;
    logic [7:0] m_data;
    int m_mode, m_cnt;

    always @(posedge clk) begin
        bit launch;
        if (!rst_n) begin
            m_s0 <= 0; m_s1 <= 0; m_prev <= 0; m_flag <= 0; m_skipn <= 1;
            m_xfer <= 0; m_data <= 0; m_pend <= 0; m_startn <= 1; m_mode <= 0; m_cnt <= 0;
        end else begin
            m_s0 <= ~ready_n;
            m_s1 <= m_s0;
            m_prev <= m_s1;
            if (m_s1 && !m_prev) m_flag <= 1;
            else if (tp3 && (iot_read || iot_fetch || iot_read_fetch)) m_flag <= 0;
            m_skipn <= !(iot_skip && m_flag);
            m_data <= (iot_read || iot_read_fetch) ? hole_i : 8'h00;
            m_xfer <= iot_read || iot_read_fetch;
            launch = (m_mode == 0) && m_pend && m_s1;
            m_pend <= (m_pend && !launch) || (tp3 && (iot_fetch || iot_read_fetch));
            if (launch) begin
                m_mode <= 1; m_cnt <= PULSE - 1; m_startn <= 0;
            end else if (m_mode == 1) begin
                if (m_cnt == 0) begin m_mode <= 2; m_startn <= 1; end
                else m_cnt <= m_cnt - 1;
            end else if (m_mode == 2 && !m_s1) m_mode <= 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(data_o == m_data, "R2", "data_o vs model", data_o, m_data);
            chk(xfer_c0 == m_xfer && xfer_c1 == m_xfer, "R2", "xfer vs model", xfer_c0, m_xfer);
            chk(skip_n == m_skipn, "R3", "skip_n vs model (flag R4)", skip_n, m_skipn);
            chk(start_n == m_startn, "R7", "start_n vs model (R9)", start_n, m_startn);
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // kind: 0 skip, 1 read, 2 fetch, 3 combined; strobe held 4 cycles, tp3 in the third
    task automatic op(int kind);
        @(negedge clk);
        iot_skip = (kind == 0); iot_read = (kind == 1);
        iot_fetch = (kind == 2); iot_read_fetch = (kind == 3);
        idle(2);
        tp3 = 1;
        @(negedge clk);
        tp3 = 0;
        @(negedge clk);
        iot_skip = 0; iot_read = 0; iot_fetch = 0; iot_read_fetch = 0;
    endtask

    int p0;
    logic [7:0] h0;

    initial begin
        idle(3);
        chk(data_o == 0 && !xfer_c0 && !xfer_c1, "R1", "bus idle in reset", data_o, 0);
        chk(skip_n && start_n, "R1", "skip_n/start_n high in reset", {skip_n, start_n}, 3);
        rst_n = 1;
        idle(6);

        // R3/R4: flag set by ready at start-up, skip answers
        @(negedge clk); iot_skip = 1;
        @(negedge clk);
        chk(skip_n == 0, "R3", "skip asserted with flag set", skip_n, 0);
        iot_skip = 0;
        idle(2);

        // R2: read buffer gates hole lines
        h0 = hole_i;
        @(negedge clk); iot_read = 1;
        @(negedge clk);
        chk(data_o == h0 && xfer_c0 && xfer_c1, "R2", "read gates hole lines", data_o, h0);
        idle(1); tp3 = 1; @(negedge clk); tp3 = 0; iot_read = 0;
        @(negedge clk);
        chk(data_o == 0 && !xfer_c0, "R2", "bus back to zero", data_o, 0);

        // R4: read cleared the flag
        op(0);
        chk(skip_n == 1, "R4", "skip denied after read cleared flag", skip_n, 1);

        // R5: fetch issues one pulse; new char sets flag again
        p0 = pulses;
        h0 = hole_i;
        op(2);
        idle(DEV_CYC + 10);
        chk(pulses == p0 + 1, "R5", "one pulse per fetch", pulses, p0 + 1);
        chk(hole_i != h0, "R5", "tape advanced", hole_i, h0 + 8'h11);
        @(negedge clk); iot_skip = 1;
        @(negedge clk);
        chk(skip_n == 0, "R4", "flag set by new character", skip_n, 0);
        iot_skip = 0;

        // R8: combined op gates the old character then advances
        p0 = pulses;
        h0 = hole_i;
        @(negedge clk); iot_read_fetch = 1;
        @(negedge clk);
        chk(data_o == h0 && xfer_c1, "R8", "combined gates current character", data_o, h0);
        idle(1); tp3 = 1; @(negedge clk); tp3 = 0;
        @(negedge clk); iot_read_fetch = 0;
        idle(DEV_CYC + 10);
        chk(pulses == p0 + 1, "R8", "combined issues one pulse", pulses, p0 + 1);
        chk(hole_i == h0 + 8'h11, "R8", "next character after combined", hole_i, h0 + 8'h11);

        // R6: request while ready inactive is held, then honoured
        force_busy = 1;
        idle(4);
        p0 = pulses;
        op(2);
        idle(25);
        chk(pulses == p0 && start_n, "R6", "no pulse while busy", pulses, p0);
        force_busy = 0;
        idle(10);
        chk(pulses == p0 + 1, "R6", "held request fires when ready", pulses, p0 + 1);
        idle(DEV_CYC + 10);

        // R7/R9: back-to-back fetches give two separated pulses
        p0 = pulses;
        op(2);
        op(2);
        idle(8);
        chk(pulses == p0 + 1, "R7", "second pulse waits for ready cycle", pulses, p0 + 1);
        idle(2 * DEV_CYC + 20);
        chk(pulses == p0 + 2, "R9", "pending request kept", pulses, p0 + 2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule